// File: doc/BRIEF.md
# Indexed Block Register Slave on a Two-Wire Serial Bus

This block is a slave on a two-wire serial bus (clock line plus open-drain data line) that gives a host access to a small file of byte-wide configuration registers. Both directions are block transfers that begin with an index. A write gives the starting index and a byte count, then that many data bytes. A read gives the index, then a repeated start with the read address. The slave answers with a count byte and then the register contents from the index upward. The count byte is taken from a register the host may rewrite.

The bus lines are sampled by the block's own system clock, so the bus clock must be several system clocks per quarter period. The data line is never driven high. The block only pulls it low through `sda_oe_o`, and an external pull-up provides the high level. A side read port lets the surrounding chip observe any register at any time.

Top module: `idxreg_slave`

## Requirements
- R1: Address byte 0xD2 (write) and address byte 0xD3 (read) are acknowledged by pulling the data line low in the ninth clock slot.
- R2: Any other address byte is not acknowledged, and the slave leaves the data line released for every later byte until the next start condition.
- R3: In a write, the byte after the address is the start index N, the next is the count X, and X data bytes follow. Each is acknowledged, and data byte i is stored at index N+i.
- R4: A data byte beyond the count X is not acknowledged and changes no register.
- R5: In a read (0xD2, index N, repeated start, 0xD3), the slave first sends the count register's value and then sends the registers from index N upward, MSB first.
- R6: When the host answers a read byte with a not-acknowledge, the slave releases the data line and sends nothing more.
- R7: Register 8 is the readback count. It resets to 0x0F, can be written, and its current value is the count byte of every read.
- R8: Register 7 always reads 0x22, and writes to it are ignored.
- R9: Past the last register (23), the index wraps to 0 for both reads and writes. A start index of 24 or more is taken as 0.
- R10: A start or stop condition in the middle of a byte abandons the transfer. The partial byte is not stored, and bytes completed earlier stay written.
- R11: After reset, every register reads 0 except registers 7 (0x22) and 8 (0x0F). The side read port returns the addressed register, or 0 for an index of 24 or more.
- R12: The slave changes the data line only while the bus clock is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock that samples the bus |
| rst_n | input | 1 | Asynchronous active-low reset |
| scl_i | input | 1 | Bus clock line level |
| sda_i | input | 1 | Bus data line level |
| sda_oe_o | output | 1 | 1 pulls the data line low, 0 releases it |
| cfg_idx_i | input | 8 | Side read port register index |
| cfg_rdata_o | output | 8 | Side read port data (combinational) |

## Verification
A wrong bit counter or byte role appears at the ports within one byte time. It shows as an acknowledge in the wrong slot, a missing acknowledge, or a register landing at the wrong index, and that is visible on the side port after the stop. A wrong pointer or a bad wrap shows up in the first read-back that crosses index 23. A stuck drive state shows as the data line held low after a stop or after a not-acknowledge, within a few system clocks. The bench keeps a reference copy of the register file and compares against it after every transfer, both through bus reads and through the side port.

// File: rtl/idxreg_pkg.sv
package idxreg_pkg;

    typedef enum logic [2:0] {
        S_IDLE,
        S_ADDR,
        S_RX,
        S_ACK,
        S_TX,
        S_TXACK
    } bus_st_e;

    typedef enum logic [1:0] {
        ROLE_IDX,
        ROLE_CNT,
        ROLE_DAT
    } byte_role_e;

    typedef struct packed {
        bus_st_e    st;
        byte_role_e role;
        logic       rd_mode;
        logic       got;
        logic       nack;
        logic       drv;
        logic [2:0] bitc;
        logic [7:0] sh;
        logic [7:0] ptr;
        logic [7:0] cnt;
    } fsm_t;

endpackage

// File: rtl/idxreg_buscond.sv
module idxreg_buscond (
    input  logic clk,
    input  logic rst_n,
    input  logic scl_i,
    input  logic sda_i,
    output logic sda_v_o,
    output logic rise_o,
    output logic fall_o,
    output logic start_o,
    output logic stop_o
);
    typedef struct packed {
        logic [1:0] scl_m;
        logic [1:0] sda_m;
        logic       scl_p;
        logic       sda_p;
    } sync_t;

    sync_t q, d;

    always_comb begin
        d       = q;
        d.scl_m = {q.scl_m[0], scl_i};
        d.sda_m = {q.sda_m[0], sda_i};
        d.scl_p = q.scl_m[1];
        d.sda_p = q.sda_m[1];
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q <= '1;
        else        q <= d;
    end

    assign sda_v_o = q.sda_m[1];
    assign rise_o  =  q.scl_m[1] & ~q.scl_p;
    assign fall_o  = ~q.scl_m[1] &  q.scl_p;
    assign start_o =  q.scl_m[1] &  q.scl_p &  q.sda_p & ~q.sda_m[1];
    assign stop_o  =  q.scl_m[1] &  q.scl_p & ~q.sda_p &  q.sda_m[1];
endmodule

// File: rtl/idxreg_regs.sv
module idxreg_regs #(
    parameter int          NREG    = 24,
    parameter int          ID_IDX  = 7,
    parameter logic [7:0]  ID_VAL  = 8'h22,
    parameter int          CNT_IDX = 8,
    parameter logic [7:0]  CNT_RST = 8'h0F
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       we_i,
    input  logic [7:0] widx_i,
    input  logic [7:0] wdata_i,
    input  logic [7:0] ra_idx_i,
    output logic [7:0] ra_data_o,
    input  logic [7:0] rb_idx_i,
    output logic [7:0] rb_data_o,
    output logic [7:0] cnt_o
);
    logic [7:0] mem [NREG];

    for (genvar gi = 0; gi < NREG; gi++) begin : g_reg
        if (gi == ID_IDX) begin : g_fixed
            assign mem[gi] = ID_VAL;
        end else begin : g_rw
            localparam logic [7:0] RST_V = (gi == CNT_IDX) ? CNT_RST : 8'h00;
            logic [7:0] r_q, r_d;
            always_comb begin
                r_d = r_q;
                if (we_i && widx_i == 8'(gi)) r_d = wdata_i;
            end
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) r_q <= RST_V;
                else        r_q <= r_d;
            end
            assign mem[gi] = r_q;
        end
    end

    always_comb begin
        ra_data_o = 8'h00;
        rb_data_o = 8'h00;
        for (int i = 0; i < NREG; i++) begin
            if (ra_idx_i == 8'(i)) ra_data_o = mem[i];
            if (rb_idx_i == 8'(i)) rb_data_o = mem[i];
        end
    end

    assign cnt_o = mem[CNT_IDX];
endmodule

// File: rtl/idxreg_slave.sv
module idxreg_slave #(
    parameter int          NREG    = 24,
    parameter logic [7:0]  WR_ADDR = 8'hD2,
    parameter logic [7:0]  RD_ADDR = 8'hD3,
    parameter int          ID_IDX  = 7,
    parameter logic [7:0]  ID_VAL  = 8'h22,
    parameter int          CNT_IDX = 8,
    parameter logic [7:0]  CNT_RST = 8'h0F
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       scl_i,
    input  logic       sda_i,
    output logic       sda_oe_o,
    input  logic [7:0] cfg_idx_i,
    output logic [7:0] cfg_rdata_o
);
    import idxreg_pkg::*;

    localparam logic [7:0] LAST = 8'(NREG - 1);

    logic       sda_v, ev_rise, ev_fall, ev_start, ev_stop;
    logic       we;
    logic [7:0] rd_data, cnt_val;
    logic       bus_idle;
    fsm_t       q, d;

    idxreg_buscond u_cond (
        .clk     (clk),
        .rst_n   (rst_n),
        .scl_i   (scl_i),
        .sda_i   (sda_i),
        .sda_v_o (sda_v),
        .rise_o  (ev_rise),
        .fall_o  (ev_fall),
        .start_o (ev_start),
        .stop_o  (ev_stop)
    );

    idxreg_regs #(
        .NREG(NREG), .ID_IDX(ID_IDX), .ID_VAL(ID_VAL),
        .CNT_IDX(CNT_IDX), .CNT_RST(CNT_RST)
    ) u_regs (
        .clk       (clk),
        .rst_n     (rst_n),
        .we_i      (we),
        .widx_i    (q.ptr),
        .wdata_i   (q.sh),
        .ra_idx_i  (q.ptr),
        .ra_data_o (rd_data),
        .rb_idx_i  (cfg_idx_i),
        .rb_data_o (cfg_rdata_o),
        .cnt_o     (cnt_val)
    );

    function automatic logic [7:0] step(input logic [7:0] p);
        return (p == LAST) ? 8'd0 : p + 8'd1;
    endfunction

    always_comb begin
        d  = q;
        we = 1'b0;
        if (ev_stop) begin
            d.st  = S_IDLE;
            d.drv = 1'b0;
            d.got = 1'b0;
        end else if (ev_start) begin
            d.st   = S_ADDR;
            d.bitc = 3'd0;
            d.got  = 1'b0;
            d.drv  = 1'b0;
        end else begin
            unique case (q.st)
                S_ADDR, S_RX: begin
                    if (ev_rise) begin
                        d.sh   = {q.sh[6:0], sda_v};
                        d.bitc = q.bitc + 3'd1;
                        if (q.bitc == 3'd7) d.got = 1'b1;
                    end else if (ev_fall && q.got) begin
                        d.got = 1'b0;
                        d.st  = S_ACK;
                        d.drv = 1'b1;
                        if (q.st == S_ADDR) begin
                            if (q.sh == WR_ADDR) begin
                                d.rd_mode = 1'b0;
                                d.role    = ROLE_IDX;
                            end else if (q.sh == RD_ADDR) begin
                                d.rd_mode = 1'b1;
                            end else begin
                                d.st  = S_IDLE;
                                d.drv = 1'b0;
                            end
                        end else begin
                            unique case (q.role)
                                ROLE_IDX: begin
                                    d.ptr  = (q.sh <= LAST) ? q.sh : 8'd0;
                                    d.role = ROLE_CNT;
                                end
                                ROLE_CNT: begin
                                    d.cnt  = q.sh;
                                    d.role = ROLE_DAT;
                                end
                                default: begin
                                    if (q.cnt != 8'd0) begin
                                        we    = 1'b1;
                                        d.ptr = step(q.ptr);
                                        d.cnt = q.cnt - 8'd1;
                                    end else begin
                                        d.st  = S_IDLE;
                                        d.drv = 1'b0;
                                    end
                                end
                            endcase
                        end
                    end
                end
                S_ACK: begin
                    if (ev_fall) begin
                        d.bitc = 3'd0;
                        if (q.rd_mode) begin
                            d.st  = S_TX;
                            d.sh  = cnt_val;
                            d.drv = ~cnt_val[7];
                        end else begin
                            d.st  = S_RX;
                            d.drv = 1'b0;
                        end
                    end
                end
                S_TX: begin
                    if (ev_fall) begin
                        if (q.bitc == 3'd7) begin
                            d.st   = S_TXACK;
                            d.drv  = 1'b0;
                            d.bitc = 3'd0;
                        end else begin
                            d.sh   = {q.sh[6:0], 1'b0};
                            d.bitc = q.bitc + 3'd1;
                            d.drv  = ~q.sh[6];
                        end
                    end
                end
                S_TXACK: begin
                    if (ev_rise) begin
                        d.nack = sda_v;
                    end else if (ev_fall) begin
                        if (q.nack) begin
                            d.st = S_IDLE;
                        end else begin
                            d.st   = S_TX;
                            d.sh   = rd_data;
                            d.ptr  = step(q.ptr);
                            d.bitc = 3'd0;
                            d.drv  = ~rd_data[7];
                        end
                    end
                end
                default: ;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q         <= '0;
            q.st      <= S_IDLE;
            q.role    <= ROLE_IDX;
        end else begin
            q <= d;
        end
    end

    assign sda_oe_o = q.drv;
    assign bus_idle = (q.st == S_IDLE);
endmodule

// File: rtl/idxreg_slave_chk.sv
module idxreg_slave_chk #(
    parameter int         NREG   = 24,
    parameter int         ID_IDX = 7,
    parameter logic [7:0] ID_VAL = 8'h22
) (
    input logic       clk,
    input logic       rst_n,
    input logic       scl_i,
    input logic       sda_oe_o,
    input logic [7:0] cfg_idx_i,
    input logic [7:0] cfg_rdata_o,
    input logic       stop_ev,
    input logic       idle,
    input logic       we,
    input logic [7:0] widx
);
    a_r12_drive_change_scl_low: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(sda_oe_o) |-> !scl_i);

    a_r8_id_fixed: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg_idx_i == 8'(ID_IDX)) |-> (cfg_rdata_o == ID_VAL));

    a_r2_idle_released: assert property (@(posedge clk) disable iff (!rst_n)
        idle |-> !sda_oe_o);

    a_r6_stop_releases: assert property (@(posedge clk) disable iff (!rst_n)
        stop_ev |=> !sda_oe_o);

    a_r9_write_in_range: assert property (@(posedge clk) disable iff (!rst_n)
        we |-> (widx < 8'(NREG)));

    a_r11_side_port_range: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg_idx_i >= 8'(NREG)) |-> (cfg_rdata_o == 8'h00));
endmodule

bind idxreg_slave idxreg_slave_chk #(
    .NREG(NREG), .ID_IDX(ID_IDX), .ID_VAL(ID_VAL)
) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .scl_i       (scl_i),
    .sda_oe_o    (sda_oe_o),
    .cfg_idx_i   (cfg_idx_i),
    .cfg_rdata_o (cfg_rdata_o),
    .stop_ev     (ev_stop),
    .idle        (bus_idle),
    .we          (we),
    .widx        (q.ptr)
);

// File: tb/idxreg_slave_bench.sv
`timescale 1ns/1ps
module idxreg_slave_bench;
    localparam int Q = 6;
    localparam int N = 24;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       m_scl_low = 1'b0;
    logic       m_sda_low = 1'b0;
    logic       sda_oe;
    logic [7:0] cfg_idx = 8'd0;
    logic [7:0] cfg_rdata;
    wire        scl_bus = ~m_scl_low;
    wire        sda_bus = ~(m_sda_low | sda_oe);

    int checks = 0;
    int errors = 0;
    bit done   = 1'b0;
    logic [7:0] model [N];
    logic [7:0] wbuf [8];

    always #2.5 clk = ~clk;

    idxreg_slave u_idxreg_slave (
        .clk(clk), .rst_n(rst_n), .scl_i(scl_bus), .sda_i(sda_bus),
        .sda_oe_o(sda_oe), .cfg_idx_i(cfg_idx), .cfg_rdata_o(cfg_rdata)
    );

    function automatic int eff(input int n);
        return (n < N) ? n : 0;
    endfunction

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic wq();
        repeat (Q) @(negedge clk);
    endtask

    task automatic m_start();
        m_sda_low = 1'b0; wq();
        m_scl_low = 1'b0; wq();
        m_sda_low = 1'b1; wq();
        m_scl_low = 1'b1; wq();
    endtask

    task automatic m_stop();
        m_sda_low = 1'b1; wq();
        m_scl_low = 1'b0; wq();
        m_sda_low = 1'b0; wq();
    endtask

    task automatic m_bit_wr(input bit b);
        m_sda_low = ~b; wq();
        m_scl_low = 1'b0; wq(); wq();
        m_scl_low = 1'b1; wq();
    endtask

    task automatic m_bit_rd(output bit b);
        m_sda_low = 1'b0; wq();
        m_scl_low = 1'b0; wq();
        b = sda_bus; wq();
        m_scl_low = 1'b1; wq();
    endtask

    task automatic m_byte_wr(input logic [7:0] v, output bit ack);
        bit s;
        for (int i = 7; i >= 0; i--) m_bit_wr(v[i]);
        m_bit_rd(s);
        ack = ~s;
    endtask

    task automatic m_byte_rd(input bit nack, output logic [7:0] v);
        bit s;
        for (int i = 0; i < 8; i++) begin
            m_bit_rd(s);
            v = {v[6:0], s};
        end
        m_bit_wr(nack);
    endtask

    task automatic cfg_check(input string req);
        for (int i = 0; i < N; i++) begin
            cfg_idx = 8'(i);
            #1;
            chk(cfg_rdata == model[i], req, cfg_rdata, model[i]);
            @(negedge clk);
        end
    endtask

    task automatic bus_write(input int n, input int x, input int nsend, input string req);
        bit a;
        int s;
        s = eff(n);
        m_start();
        m_byte_wr(8'hD2, a); chk(a, "R1 write address ack", a, 1);
        m_byte_wr(8'(n), a); chk(a, req, a, 1);
        m_byte_wr(8'(x), a); chk(a, req, a, 1);
        for (int i = 0; i < nsend; i++) begin
            m_byte_wr(wbuf[i], a);
            if (i < x) begin
                chk(a, req, a, 1);
                if ((s + i) % N != 7) model[(s + i) % N] = wbuf[i];
            end else begin
                chk(!a, "R4 byte past count not acked", a, 0);
            end
        end
        m_stop();
    endtask

    task automatic bus_read(input int n, input int k, input string req);
        bit a;
        int s;
        logic [7:0] v;
        s = eff(n);
        m_start();
        m_byte_wr(8'hD2, a); chk(a, "R1 write address ack", a, 1);
        m_byte_wr(8'(n), a); chk(a, req, a, 1);
        m_start();
        m_byte_wr(8'hD3, a); chk(a, "R1 read address ack", a, 1);
        m_byte_rd(1'b0, v);
        chk(v == model[8], "R7 count byte from register 8", v, model[8]);
        for (int i = 0; i < k; i++) begin
            m_byte_rd(i == k - 1, v);
            chk(v == model[(s + i) % N], req, v, model[(s + i) % N]);
        end
        wq();
        chk(sda_oe == 1'b0, "R6 released after nack", sda_oe, 0);
        m_stop();
    endtask

    initial begin
        repeat (190000) @(posedge clk);
        if (!done) begin
            errors++;
            checks++;
            $display("FAIL watchdog expired");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        bit a;
        int n, x;
        void'($urandom(32'h1d3c));
        for (int i = 0; i < N; i++) model[i] = 8'h00;
        model[7] = 8'h22;
        model[8] = 8'h0F;
        repeat (5) @(negedge clk);
        rst_n = 1'b1;
        repeat (5) @(negedge clk);

        chk(sda_oe == 1'b0, "R11 reset released", sda_oe, 0);
        cfg_check("R11 reset value");
        cfg_idx = 8'd30; #1;
        chk(cfg_rdata == 8'h00, "R11 side port out of range", cfg_rdata, 0);
        @(negedge clk);

        // R3 plain block write then R5 read back
        wbuf[0] = 8'hA1; wbuf[1] = 8'hB2; wbuf[2] = 8'hC3;
        bus_write(2, 3, 3, "R3 block write");
        cfg_check("R3 stored at N+i");
        bus_read(2, 3, "R5 block read data");

        // R4 extra byte beyond count
        wbuf[0] = 8'h11; wbuf[1] = 8'h99;
        bus_write(10, 1, 2, "R4 write with extra");
        cfg_check("R4 extra byte not stored");

        // R8 write across ID register
        wbuf[0] = 8'h66; wbuf[1] = 8'h77; wbuf[2] = 8'h04;
        bus_write(6, 3, 3, "R8 write over id");
        cfg_check("R8 id unchanged, R7 count written");
        bus_read(5, 4, "R7 read length from new count");

        // R9 wrap on write and read, oversized index
        wbuf[0] = 8'hE0; wbuf[1] = 8'hE1; wbuf[2] = 8'hE2; wbuf[3] = 8'hE3;
        bus_write(22, 4, 4, "R9 write wrap");
        cfg_check("R9 wrapped store");
        bus_read(23, 3, "R9 read wrap");
        wbuf[0] = 8'h5C;
        bus_write(200, 1, 1, "R9 large index as 0");
        cfg_check("R9 large index store");

        // R2 foreign address
        m_start();
        m_byte_wr(8'hA4, a); chk(!a, "R2 foreign address nack", a, 0);
        m_byte_wr(8'hD2, a); chk(!a, "R2 silent until start", a, 0);
        m_stop();
        cfg_check("R2 nothing written");

        // R10 stop inside a data byte
        m_start();
        m_byte_wr(8'hD2, a); m_byte_wr(8'd3, a); m_byte_wr(8'd2, a);
        m_byte_wr(8'h5A, a); chk(a, "R10 first byte acked", a, 1);
        model[3] = 8'h5A;
        for (int i = 0; i < 4; i++) m_bit_wr(1'b1);
        m_stop();
        cfg_check("R10 stop aborts partial byte");

        // R10 start inside a data byte
        m_start();
        m_byte_wr(8'hD2, a); m_byte_wr(8'd12, a); m_byte_wr(8'd1, a);
        for (int i = 0; i < 3; i++) m_bit_wr(1'b0);
        m_start();
        m_stop();
        cfg_check("R10 start aborts partial byte");

        // random traffic
        for (int r = 0; r < 12; r++) begin
            n = $urandom % 28;
            x = 1 + $urandom % 4;
            for (int i = 0; i < 4; i++) wbuf[i] = 8'($urandom);
            bus_write(n, x, x, "R3 random write");
            bus_read(n, x, "R5 random read");
        end
        cfg_check("R11 final side port");

        done = 1'b1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule